// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block controls a port of general-purpose I/O lines. Each line is driven either by the controller's own output-data and output-enable registers, or by one of up to two peripheral functions. Which lines have which peripherals is fixed at build time by two per-line mask parameters. A small register bus with one-cycle accesses programs the port through write-only set/clear pairs and reads back status. Configuration writes always work. The input side is different: it samples the pads and logs level changes only while the port clock enable from the power management logic is high.

The input side is built around a three-state sensing machine:
- **GATED** is the reset state. Entered from any state when the enable drops (transition *gate-off*).
- **FILL** lasts one enabled cycle after the enable returns (transition *wake*, GATED→FILL). During it the synchroniser refills, so stale levels are never reported as changes.
- **LIVE** is reached with transition *settle* (FILL→LIVE). It stays in LIVE while the enable holds (transition *hold*). Change detection runs only in LIVE.

A line whose synchronised level moves while its change-interrupt enable is set raises a sticky status bit. The interrupt output is the OR of the pending and enabled bits, gated by the port clock enable.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset:
  - `pad_out`, `pad_oe` and `irq` are 0.
  - The owner register reads all ones.
  - The select register reads `HAS_B & ~HAS_A`.
  - Every other readable register, including the pin status, reads 0.
- R2: Set/clear pairs. Writing a 1 bit at a SET address sets that register bit, and writing a 1 bit at a CLR address clears it. Zero bits leave the register unchanged. The addresses are:
  - owner: 0/1
  - output enable: 2/3
  - output data: 4/5
  - change-interrupt enable: 6/7
  - select-A: 8 (clears select bits)
  - select-B: 9 (sets select bits)
  Reads return: owner at 0, output enable at 2, output data at 4, interrupt enable at 6, select at 8, pin status at 12, change status at 13. Any other address reads 0.
- R3: Masked writes on lines without a matching peripheral:
  - An owner-clear has no effect on a line with no peripheral, so the controller keeps the pin.
  - Select-B has no effect on a line without peripheral B.
  - Select-A has no effect on a line without peripheral A.
- R4: When a line's owner bit is 1, `pad_out` and `pad_oe` follow the output-data and output-enable bits. When the owner bit is 0, they follow peripheral B's signals if the select bit is 1, and peripheral A's signals otherwise.
- R5: All configuration writes take effect while `port_clk_en` is 0.
- R6: Pin status is the pad level after a two-flop synchroniser that advances only on enabled edges. A pad change is visible after the second enabled edge. The value stays frozen while the enable is low.
- R7: In LIVE, a synchronised level change on a line with its interrupt-enable bit set sets that line's change-status bit at the same edge the new level reaches pin status. Changes that arrive while gated, or during FILL, are not logged.
- R8: Reading address 13 returns the change status and clears it at that edge, except for bits newly detected at the same edge.
- R9: `irq` = `port_clk_en` AND (OR of change status AND interrupt enable). Clearing an enable bit masks the interrupt but keeps the status bit.
- R10: The sensing machine follows wake, settle, hold and gate-off as described, and spends exactly one enabled cycle in FILL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_clk_en | input | 1 | Input-side clock enable from power management |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data, one bit per line |
| bus_rdata | output | 32 | Read data, combinational on the address |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables |
| fa_out | input | 32 | Peripheral A output levels |
| fa_oe | input | 32 | Peripheral A output enables |
| fb_out | input | 32 | Peripheral B output levels |
| fb_oe | input | 32 | Peripheral B output enables |
| irq | output | 1 | Input-change interrupt |

## Verification
Pad outputs and register read-back change at the clock edge that completes a write. The bench therefore samples them one time step after that edge. Read data is combinational and is sampled mid-cycle, before the clearing edge. A pad change reaches pin status and change status at the second enabled edge, so the bench checks that `irq` is still low after one edge and high after two. The `irq` response to `port_clk_en` needs no edge and is checked right after the enable is toggled between edges.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    typedef enum logic [3:0] {
        A_OWN_SET = 4'd0,
        A_OWN_CLR = 4'd1,
        A_OE_SET  = 4'd2,
        A_OE_CLR  = 4'd3,
        A_OD_SET  = 4'd4,
        A_OD_CLR  = 4'd5,
        A_IE_SET  = 4'd6,
        A_IE_CLR  = 4'd7,
        A_SEL_A   = 4'd8,
        A_SEL_B   = 4'd9,
        A_PIN     = 4'd12,
        A_CHG     = 4'd13
    } reg_addr_e;

    typedef enum logic [1:0] {
        S_GATED = 2'd0,
        S_FILL  = 2'd1,
        S_LIVE  = 2'd2
    } sense_state_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int          LINES = 32,
    parameter logic [LINES-1:0] HAS_A = '0,
    parameter logic [LINES-1:0] HAS_B = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       addr,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] own_q,
    output logic [LINES-1:0] oe_q,
    output logic [LINES-1:0] od_q,
    output logic [LINES-1:0] ie_q,
    output logic [LINES-1:0] sel_q
);
    localparam logic [LINES-1:0] HAS_ANY = HAS_A | HAS_B;
    localparam logic [LINES-1:0] SEL_RST = HAS_B & ~HAS_A;

    reg_addr_e waddr;
    assign waddr = reg_addr_e'(addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_q <= '1;
            oe_q  <= '0;
            od_q  <= '0;
            ie_q  <= '0;
            sel_q <= SEL_RST;
        end else if (wr_en) begin
            case (waddr)
                A_OWN_SET: own_q <= own_q | wdata;
                A_OWN_CLR: own_q <= own_q & ~(wdata & HAS_ANY);
                A_OE_SET:  oe_q  <= oe_q | wdata;
                A_OE_CLR:  oe_q  <= oe_q & ~wdata;
                A_OD_SET:  od_q  <= od_q | wdata;
                A_OD_CLR:  od_q  <= od_q & ~wdata;
                A_IE_SET:  ie_q  <= ie_q | wdata;
                A_IE_CLR:  ie_q  <= ie_q & ~wdata;
                A_SEL_A:   sel_q <= sel_q & ~(wdata & HAS_A);
                A_SEL_B:   sel_q <= sel_q | (wdata & HAS_B);
                default:   ;
            endcase
        end
    end

    // R3: lines without a peripheral never lose controller ownership
    a_r3_fixed_lines: assert property (@(posedge clk) disable iff (!rst_n)
        ((~own_q) & ~HAS_ANY) == '0);

    // R2: an output-enable set write lands by the next cycle
    a_r2_oe_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && waddr == A_OE_SET) |=> ((oe_q & $past(wdata)) == $past(wdata)));

    // R3: selection never points at an absent peripheral on a peripheral line
    a_r3_sel_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_q & ~HAS_B & HAS_A) == '0));
endmodule

// File: rtl/gpio_outmux.sv
module gpio_outmux #(
    parameter int          LINES = 32,
    parameter logic [LINES-1:0] HAS_A = '0,
    parameter logic [LINES-1:0] HAS_B = '0
) (
    input  logic [LINES-1:0] own_q,
    input  logic [LINES-1:0] sel_q,
    input  logic [LINES-1:0] oe_q,
    input  logic [LINES-1:0] od_q,
    input  logic [LINES-1:0] fa_out,
    input  logic [LINES-1:0] fa_oe,
    input  logic [LINES-1:0] fb_out,
    input  logic [LINES-1:0] fb_oe,
    output logic [LINES-1:0] pad_out,
    output logic [LINES-1:0] pad_oe
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        if (HAS_A[i] || HAS_B[i]) begin : g_muxed
            logic p_out, p_oe;
            always_comb begin
                if (sel_q[i]) begin
                    p_out = fb_out[i];
                    p_oe  = fb_oe[i];
                end else begin
                    p_out = fa_out[i];
                    p_oe  = fa_oe[i];
                end
            end
            assign pad_out[i] = own_q[i] ? od_q[i] : p_out;
            assign pad_oe[i]  = own_q[i] ? oe_q[i] : p_oe;
        end else begin : g_plain
            assign pad_out[i] = od_q[i];
            assign pad_oe[i]  = oe_q[i];
        end
    end
endmodule

// File: rtl/gpio_insense.sv
module gpio_insense
    import gpio_port_pkg::*;
#(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic [LINES-1:0] pad_in,
    input  logic [LINES-1:0] ie_q,
    input  logic             chg_rd,
    output logic [LINES-1:0] pin_lvl,
    output logic [LINES-1:0] chg_q
);
    sense_state_e state_q, state_d;
    logic [LINES-1:0] sync1, sync2;
    logic detect_on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_GATED;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            S_GATED: state_d = clk_en ? S_FILL : S_GATED;
            S_FILL:  state_d = clk_en ? S_LIVE : S_GATED;
            S_LIVE:  state_d = clk_en ? S_LIVE : S_GATED;
            default: state_d = S_GATED;
        endcase
    end

    always_comb begin
        detect_on = (state_q == S_LIVE) && clk_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= '0;
            sync2 <= '0;
        end else if (clk_en) begin
            sync1 <= pad_in;
            sync2 <= sync1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chg_q <= '0;
        else        chg_q <= (chg_rd ? '0 : chg_q)
                             | (detect_on ? ((sync1 ^ sync2) & ie_q) : '0);
    end

    assign pin_lvl = sync2;

    // R6: pin level frozen while the port clock is gated
    a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(pin_lvl));

    // R7: no new change events outside LIVE
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_LIVE) |=> ((chg_q & ~$past(chg_q)) == '0));

    // R10: FILL lasts a single cycle
    a_r10_fill_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FILL) |=> (state_q != S_FILL));
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
    import gpio_port_pkg::*;
#(
    parameter int          LINES = 32,
    parameter logic [LINES-1:0] HAS_A = 32'h00FF_FF00,
    parameter logic [LINES-1:0] HAS_B = 32'h0F0F_0F00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_clk_en,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [3:0]       bus_addr,
    input  logic [LINES-1:0] bus_wdata,
    output logic [LINES-1:0] bus_rdata,
    input  logic [LINES-1:0] pad_in,
    output logic [LINES-1:0] pad_out,
    output logic [LINES-1:0] pad_oe,
    input  logic [LINES-1:0] fa_out,
    input  logic [LINES-1:0] fa_oe,
    input  logic [LINES-1:0] fb_out,
    input  logic [LINES-1:0] fb_oe,
    output logic             irq
);
    logic [LINES-1:0] own_q, oe_q, od_q, ie_q, sel_q, pin_lvl, chg_q;
    logic chg_rd;
    reg_addr_e raddr;

    assign raddr  = reg_addr_e'(bus_addr);
    assign chg_rd = bus_rd && (raddr == A_CHG);

    gpio_regs #(.LINES(LINES), .HAS_A(HAS_A), .HAS_B(HAS_B)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .own_q(own_q), .oe_q(oe_q), .od_q(od_q),
        .ie_q(ie_q), .sel_q(sel_q)
    );

    gpio_outmux #(.LINES(LINES), .HAS_A(HAS_A), .HAS_B(HAS_B)) u_mux (
        .own_q(own_q), .sel_q(sel_q), .oe_q(oe_q), .od_q(od_q),
        .fa_out(fa_out), .fa_oe(fa_oe), .fb_out(fb_out), .fb_oe(fb_oe),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    gpio_insense #(.LINES(LINES)) u_sense (
        .clk(clk), .rst_n(rst_n), .clk_en(port_clk_en), .pad_in(pad_in),
        .ie_q(ie_q), .chg_rd(chg_rd), .pin_lvl(pin_lvl), .chg_q(chg_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (raddr)
                A_OWN_SET: bus_rdata = own_q;
                A_OE_SET:  bus_rdata = oe_q;
                A_OD_SET:  bus_rdata = od_q;
                A_IE_SET:  bus_rdata = ie_q;
                A_SEL_A:   bus_rdata = sel_q;
                A_PIN:     bus_rdata = pin_lvl;
                A_CHG:     bus_rdata = chg_q;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign irq = port_clk_en && |(chg_q & ie_q);

    // R8: a status read leaves no stale bit that was not newly detected
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        chg_rd |=> ((chg_q & $past(chg_q) & ~($past(pin_lvl) ^ pin_lvl)) == '0));
endmodule

// File: tb/gpio_mux_port_test.sv
module gpio_mux_port_test;
    localparam int N = 32;
    localparam logic [N-1:0] HA = 32'h00FF_FF00;
    localparam logic [N-1:0] HB = 32'h0F0F_0F00;
    localparam logic [N-1:0] HANY = HA | HB;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, port_clk_en, bus_wr, bus_rd, irq;
    logic [3:0] bus_addr;
    logic [N-1:0] bus_wdata, bus_rdata, pad_in, pad_out, pad_oe;
    logic [N-1:0] fa_out, fa_oe, fb_out, fb_oe;

    gpio_mux_port #(.LINES(N), .HAS_A(HA), .HAS_B(HB)) uut (
        .clk(clk), .rst_n(rst_n), .port_clk_en(port_clk_en),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .fa_out(fa_out), .fa_oe(fa_oe),
        .fb_out(fb_out), .fb_oe(fb_oe), .irq(irq)
    );

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [N-1:0] m_own, m_oe, m_od, m_ie, m_sel;

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_pad(input bit want_oe);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            if (m_own[i]) r[i] = want_oe ? m_oe[i] : m_od[i];
            else if (m_sel[i]) r[i] = want_oe ? fb_oe[i] : fb_out[i];
            else r[i] = want_oe ? fa_oe[i] : fa_out[i];
        end
        return r;
    endfunction

    function automatic logic [N-1:0] exp_read(input logic [3:0] a);
        case (a)
            4'd0: return m_own;
            4'd2: return m_oe;
            4'd4: return m_od;
            4'd6: return m_ie;
            4'd8: return m_sel;
            default: return '0;
        endcase
    endfunction

    task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
        case (a)
            4'd0: m_own = m_own | d;
            4'd1: m_own = m_own & ~(d & HANY);
            4'd2: m_oe = m_oe | d;
            4'd3: m_oe = m_oe & ~d;
            4'd4: m_od = m_od | d;
            4'd5: m_od = m_od & ~d;
            4'd6: m_ie = m_ie | d;
            4'd7: m_ie = m_ie & ~d;
            4'd8: m_sel = m_sel & ~(d & HA);
            4'd9: m_sel = m_sel | (d & HB);
            default: ;
        endcase
    endtask

    task automatic rd(input logic [3:0] a, output logic [N-1:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [N-1:0] v;
        void'($urandom(32'd20240611));
        rst_n = 0; port_clk_en = 0; bus_wr = 0; bus_rd = 0; bus_addr = '0;
        bus_wdata = '0; pad_in = '0; fa_out = '0; fa_oe = '0; fb_out = '0; fb_oe = '0;
        m_own = '1; m_oe = '0; m_od = '0; m_ie = '0; m_sel = HB & ~HA;
        idle(3);
        @(negedge clk) rst_n = 1;
        idle(1);

        // R1 reset state
        chk("R1 pad_out", pad_out, '0);
        chk("R1 pad_oe", pad_oe, '0);
        chk("R1 irq", {31'd0, irq}, '0);
        rd(4'd0, v); chk("R1 owner", v, '1);
        rd(4'd8, v); chk("R1 select", v, HB & ~HA);
        rd(4'd12, v); chk("R1 pin", v, '0);

        // R5/R6: gated clock, config writes work, pin frozen
        pad_in = '1;
        idle(4);
        rd(4'd12, v); chk("R6 pin frozen while gated", v, '0);
        wr(4'd6, 32'h0000_0007);
        rd(4'd6, v); chk("R5 ie write while gated", v, 32'h7);
        wr(4'd2, 32'h0000_000F);
        wr(4'd4, 32'h0000_0005);
        chk("R5 oe while gated", pad_oe, 32'hF);
        chk("R4 out from data reg", pad_out, 32'h5);

        // R10/R7: wake and refill without false events
        port_clk_en = 1;
        idle(3);
        rd(4'd12, v); chk("R6 pin after enable", v, '1);
        rd(4'd13, v); chk("R7 no event from refill", v, '0);
        chk("R9 irq idle", {31'd0, irq}, '0);

        // R7/R9 timing of a change
        pad_in[0] = 0; pad_in[9] = 0;
        idle(1);
        chk("R7 irq not yet after one edge", {31'd0, irq}, '0);
        idle(1);
        chk("R9 irq after two edges", {31'd0, irq}, 32'h1);
        rd(4'd13, v); chk("R8 status read (bit9 not enabled)", v, 32'h1);
        chk("R8 irq cleared by read", {31'd0, irq}, '0);
        rd(4'd13, v); chk("R8 status empty after read", v, '0);

        // R9 gating and masking
        pad_in[1] = 0;
        idle(2);
        chk("R9 irq on bit1", {31'd0, irq}, 32'h1);
        port_clk_en = 0; #1;
        chk("R9 irq gated by enable", {31'd0, irq}, '0);
        port_clk_en = 1; #1;
        chk("R9 irq back with enable", {31'd0, irq}, 32'h1);
        wr(4'd7, 32'h0000_0002);
        chk("R9 irq masked by ie clear", {31'd0, irq}, '0);
        rd(4'd13, v); chk("R9 status kept when masked", v, 32'h2);

        // R7/R10: change while gated is not logged
        port_clk_en = 0;
        idle(1);
        pad_in[2] = 0;
        idle(3);
        rd(4'd12, v); chk("R6 pin frozen during gate", v, 32'hFFFF_FDFC);
        port_clk_en = 1;
        idle(4);
        rd(4'd13, v); chk("R10 gated change not logged", v, '0);
        rd(4'd12, v); chk("R6 pin updated after wake", v, 32'hFFFF_FDF8);
        pad_in[2] = 1;
        idle(2);
        rd(4'd13, v); chk("R10 live detection resumed", v, 32'h4);

        // R3 masked owner clear and select
        wr(4'd1, '1);
        rd(4'd0, v); chk("R3 owner clear masked", v, ~HANY);
        wr(4'd9, '1);
        rd(4'd8, v); chk("R3 select B masked", v, HB);
        wr(4'd8, '1);
        rd(4'd8, v); chk("R3 select A masked", v, HB & ~HA);

        // R2/R4 constrained random
        for (int it = 0; it < 400; it++) begin
            logic [3:0] a;
            @(negedge clk);
            fa_out = $urandom; fa_oe = $urandom; fb_out = $urandom; fb_oe = $urandom;
            a = 4'($urandom_range(0, 9));
            wr(a, $urandom);
            chk("R4 pad_out", pad_out, exp_pad(0));
            chk("R4 pad_oe", pad_oe, exp_pad(1));
            if (it % 16 == 0) begin
                logic [3:0] ra;
                ra = 4'($urandom_range(0, 9));
                rd(ra, v);
                chk("R2 readback", v, exp_read(ra));
            end
        end
        rd(4'd10, v); chk("R2 unmapped address reads 0", v, '0);

        finish_run();
    end
endmodule